// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Row Buffer

This block sits between a pixel pipeline that advances at a steady rate and a memory port whose response time cannot be predicted. It carries two independent channels of 128-bit words. The load channel moves rows fetched from memory toward the pixel side. The store channel moves rows produced by the pixel side back toward memory. Each channel holds two row banks. The pixel side works in one bank while the memory side fills or empties the other. Banks change hands at row boundaries, so the memory side can run up to one full row ahead and absorb its latency jitter.

The two sides run on unrelated clocks, and the memory clock is the faster one. Ownership of each bank passes between the domains as a toggle bit per bank. Each toggle goes through a two-flop synchroniser, and the owning side flips it when it finishes with that bank. A start-of-frame pulse on the pixel side runs a four-phase request/acknowledge exchange with the memory side. The exchange empties every bank in both channels. Pixel streaming then resumes only after bank A of the load channel holds a complete new row. Two sticky flags record when the pixel side asked to advance but the buffer could not follow.

Top module: `rowbuf_ab`

## Requirements
- R1: After reset, pix_ready, pix_ld_valid, pix_underrun, pix_overrun, mem_st_rdy and mem_st_valid are all 0, and mem_ld_rdy is 1 because bank A is free to be loaded.
- R2: Words accepted on the memory side (mem_ld_we while mem_ld_rdy) appear on pix_ld_data in the same order. One word appears per accepted pixel step (pix_en while pix_ready), with pix_ld_valid high in the pixel cycle right after the step.
- R3: Words presented on pix_st_data at accepted pixel steps appear on mem_st_data in the same order. One word appears per accepted read (mem_st_re while mem_st_rdy), with mem_st_valid high in the memory cycle right after the read.
- R4: pix_ready stays 0 until a complete row of ROW_WORDS words sits in the load bank the pixel side uses next. A partly loaded row is not enough.
- R5: The memory side can load at most two rows ahead of the pixel side. mem_ld_rdy drops to 0 while both load banks hold unconsumed rows, and returns to 1 once the pixel side finishes a row.
- R6: mem_st_rdy is 1 only while a complete stored row waits to be drained. pix_ready is 0 while both store banks still wait to be drained, and returns to 1 after draining.
- R7: pix_en while the next load bank is not loaded sets pix_underrun. The request is dropped (no pix_ld_valid follows), and the flag stays set until the next start-of-frame.
- R8: pix_en while the next store bank has not been drained sets pix_overrun. The flag stays set until the next start-of-frame.
- R9: pix_sof clears both flags and discards the contents of every bank in both channels, including a load row that was ready. pix_ready and mem_st_rdy stay 0 until new data arrives, pix_en during the exchange sets no flag, and the first word the pixel side receives afterwards is the first word loaded after the exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel-side clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| pix_sof | input | 1 | Start-of-frame pulse: flush both channels |
| pix_en | input | 1 | Pixel step request: consume one load word, write one store word |
| pix_st_data | input | DATA_W | Word written into the store channel at a pixel step |
| pix_ready | output | 1 | A pixel step would be accepted this cycle |
| pix_ld_valid | output | 1 | pix_ld_data holds the word of the previous accepted step |
| pix_ld_data | output | DATA_W | Word read from the load channel |
| pix_underrun | output | 1 | Sticky: step requested without a loaded row |
| pix_overrun | output | 1 | Sticky: step requested while the store bank was undrained |
| mem_clk | input | 1 | Memory-side clock (faster than pix_clk) |
| mem_rst | input | 1 | Synchronous active-high reset, memory domain |
| mem_ld_we | input | 1 | Write one word into the load channel |
| mem_ld_data | input | DATA_W | Word for the load channel |
| mem_ld_rdy | output | 1 | The load channel accepts a word this cycle |
| mem_st_re | input | 1 | Read one word from the store channel |
| mem_st_rdy | output | 1 | A stored word can be read this cycle |
| mem_st_valid | output | 1 | mem_st_data holds the word of the previous accepted read |
| mem_st_data | output | DATA_W | Word read from the store channel |

## Verification
Several stimulus patterns are used, and each one isolates a different fault.

- A partial row followed by the missing word shows whether readiness waits for a whole row, and not just for any data.
- Running the memory side two rows ahead, with the pixel side idle and nothing drained, pins down the exact point where each side's ready must fall. This catches a bank-select or toggle-polarity fault.
- Forced pixel steps against an empty load bank, and then against an undrained store bank, separate the underrun and overrun causes. The same steps also show that a refused step moves no data.
- A start-of-frame issued while a loaded row is pending, followed by long randomly stalled traffic on both sides, shows whether stale rows leak past the flush and whether word order survives many bank swaps.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  localparam int WORD_W_DFLT    = 128;
  localparam int ROW_WORDS_DFLT = 480;
  localparam int SYNC_STAGES    = 2;

  // Flush exchange state; bit 0 is the request level sent to memory side.
  typedef enum logic [1:0] {
    FL_IDLE = 2'b00,
    FL_REQ  = 2'b01,
    FL_DROP = 2'b10
  } flush_st_e;

endpackage

// File: rtl/rowbuf_sync.sv
module rowbuf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rowbuf_dpram.sv
module rowbuf_dpram #(
  parameter int DW = 128,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rowbuf_side.sv
// One side of a two-bank channel: keeps the active bank, the word counter
// and one ownership toggle per bank, flipped when a row completes.
module rowbuf_side #(
  parameter int ROW_WORDS = 480,
  parameter bit IS_PROD   = 1'b1,
  localparam int CW = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        step,
  input  logic [1:0]  peer_tgl,
  output logic        avail,
  output logic        fire,
  output logic [CW:0] addr,
  output logic [1:0]  own_tgl
);

  localparam logic [CW-1:0] LAST = CW'(ROW_WORDS - 1);

  logic          cur;
  logic [CW-1:0] cnt;
  logic          bank_ok;

  generate
    if (IS_PROD) begin : g_prod
      // Producer may fill a bank once the consumer has handed it back.
      assign bank_ok = (own_tgl[cur] == peer_tgl[cur]);
    end else begin : g_cons
      // Consumer may read a bank once the producer has marked it filled.
      assign bank_ok = (own_tgl[cur] != peer_tgl[cur]);
    end
  endgenerate

  assign avail = bank_ok && !clr;
  assign fire  = step && avail;
  assign addr  = {cur, cnt};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      cur     <= 1'b0;
      own_tgl <= 2'b00;
    end else if (fire) begin
      if (cnt == LAST) begin
        cnt          <= '0;
        own_tgl[cur] <= ~own_tgl[cur];
        cur          <= ~cur;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rowbuf_flush.sv
// Four-phase start-of-frame exchange. Each side holds its channel state
// cleared while the request (memory side) or the exchange (pixel side) is on.
module rowbuf_flush
  import rowbuf_pkg::*;
(
  input  logic pix_clk,
  input  logic pix_rst,
  input  logic sof,
  output logic pix_clr,
  input  logic mem_clk,
  input  logic mem_rst,
  output logic mem_clr
);

  flush_st_e st;
  logic      req_p;
  logic      req_m;
  logic      ack_m;
  logic      ack_p;

  assign req_p = st[0];

  rowbuf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(mem_clk), .rst(mem_rst), .d(req_p), .q(req_m)
  );

  // Acknowledge one cycle after the clear level is applied.
  always_ff @(posedge mem_clk) begin
    if (mem_rst) ack_m <= 1'b0;
    else         ack_m <= req_m;
  end

  assign mem_clr = req_m;

  rowbuf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(pix_clk), .rst(pix_rst), .d(ack_m), .q(ack_p)
  );

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      st <= FL_IDLE;
    end else begin
      unique case (st)
        FL_IDLE: if (sof)    st <= FL_REQ;
        FL_REQ:  if (ack_p)  st <= FL_DROP;
        FL_DROP: if (!ack_p) st <= FL_IDLE;
        default:             st <= FL_IDLE;
      endcase
    end
  end

  assign pix_clr = sof || (st != FL_IDLE);

endmodule

// File: rtl/rowbuf_ab.sv
module rowbuf_ab
  import rowbuf_pkg::*;
#(
  parameter int DATA_W    = WORD_W_DFLT,
  parameter int ROW_WORDS = ROW_WORDS_DFLT
) (
  input  logic              pix_clk,
  input  logic              pix_rst,
  input  logic              pix_sof,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] pix_st_data,
  output logic              pix_ready,
  output logic              pix_ld_valid,
  output logic [DATA_W-1:0] pix_ld_data,
  output logic              pix_underrun,
  output logic              pix_overrun,
  input  logic              mem_clk,
  input  logic              mem_rst,
  input  logic              mem_ld_we,
  input  logic [DATA_W-1:0] mem_ld_data,
  output logic              mem_ld_rdy,
  input  logic              mem_st_re,
  output logic              mem_st_rdy,
  output logic              mem_st_valid,
  output logic [DATA_W-1:0] mem_st_data
);

  localparam int CW = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;
  localparam int AW = CW + 1;

  logic pix_clr, mem_clr;

  // Load channel: memory side produces, pixel side consumes.
  logic          ld_wr_avail, ld_wr_fire, ld_rd_avail, ld_rd_fire;
  logic [AW-1:0] ld_wr_addr, ld_rd_addr;
  logic [1:0]    ld_fill_tgl, ld_rel_tgl, ld_fill_s, ld_rel_s;

  // Store channel: pixel side produces, memory side consumes.
  logic          st_wr_avail, st_wr_fire, st_rd_avail, st_rd_fire;
  logic [AW-1:0] st_wr_addr, st_rd_addr;
  logic [1:0]    st_fill_tgl, st_rel_tgl, st_fill_s, st_rel_s;

  logic pix_go;

  rowbuf_flush u_flush (
    .pix_clk(pix_clk), .pix_rst(pix_rst), .sof(pix_sof), .pix_clr(pix_clr),
    .mem_clk(mem_clk), .mem_rst(mem_rst), .mem_clr(mem_clr)
  );

  // Ownership toggles crossing into the memory domain.
  rowbuf_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_p2m (
    .clk(mem_clk), .rst(mem_rst),
    .d({st_fill_tgl, ld_rel_tgl}), .q({st_fill_s, ld_rel_s})
  );

  // Ownership toggles crossing into the pixel domain.
  rowbuf_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_m2p (
    .clk(pix_clk), .rst(pix_rst),
    .d({ld_fill_tgl, st_rel_tgl}), .q({ld_fill_s, st_rel_s})
  );

  // ---------------- pixel domain ----------------
  assign pix_ready = ld_rd_avail && st_wr_avail;
  assign pix_go    = pix_en && pix_ready;

  rowbuf_side #(.ROW_WORDS(ROW_WORDS), .IS_PROD(1'b0)) u_ld_rd (
    .clk(pix_clk), .rst(pix_rst), .clr(pix_clr), .step(pix_go),
    .peer_tgl(ld_fill_s), .avail(ld_rd_avail), .fire(ld_rd_fire),
    .addr(ld_rd_addr), .own_tgl(ld_rel_tgl)
  );

  rowbuf_side #(.ROW_WORDS(ROW_WORDS), .IS_PROD(1'b1)) u_st_wr (
    .clk(pix_clk), .rst(pix_rst), .clr(pix_clr), .step(pix_go),
    .peer_tgl(st_rel_s), .avail(st_wr_avail), .fire(st_wr_fire),
    .addr(st_wr_addr), .own_tgl(st_fill_tgl)
  );

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      pix_ld_valid <= 1'b0;
      pix_underrun <= 1'b0;
      pix_overrun  <= 1'b0;
    end else begin
      pix_ld_valid <= ld_rd_fire;
      if (pix_sof) begin
        pix_underrun <= 1'b0;
        pix_overrun  <= 1'b0;
      end else if (pix_en && !pix_clr) begin
        if (!ld_rd_avail) pix_underrun <= 1'b1;
        if (!st_wr_avail) pix_overrun  <= 1'b1;
      end
    end
  end

  // ---------------- memory domain ----------------
  rowbuf_side #(.ROW_WORDS(ROW_WORDS), .IS_PROD(1'b1)) u_ld_wr (
    .clk(mem_clk), .rst(mem_rst), .clr(mem_clr), .step(mem_ld_we),
    .peer_tgl(ld_rel_s), .avail(ld_wr_avail), .fire(ld_wr_fire),
    .addr(ld_wr_addr), .own_tgl(ld_fill_tgl)
  );

  rowbuf_side #(.ROW_WORDS(ROW_WORDS), .IS_PROD(1'b0)) u_st_rd (
    .clk(mem_clk), .rst(mem_rst), .clr(mem_clr), .step(mem_st_re),
    .peer_tgl(st_fill_s), .avail(st_rd_avail), .fire(st_rd_fire),
    .addr(st_rd_addr), .own_tgl(st_rel_tgl)
  );

  assign mem_ld_rdy = ld_wr_avail;
  assign mem_st_rdy = st_rd_avail;

  always_ff @(posedge mem_clk) begin
    if (mem_rst) mem_st_valid <= 1'b0;
    else         mem_st_valid <= st_rd_fire;
  end

  // ---------------- bank storage ----------------
  rowbuf_dpram #(.DW(DATA_W), .AW(AW)) u_ld_ram (
    .wclk(mem_clk), .we(ld_wr_fire), .waddr(ld_wr_addr), .wdata(mem_ld_data),
    .rclk(pix_clk), .re(ld_rd_fire), .raddr(ld_rd_addr), .rdata(pix_ld_data)
  );

  rowbuf_dpram #(.DW(DATA_W), .AW(AW)) u_st_ram (
    .wclk(pix_clk), .we(st_wr_fire), .waddr(st_wr_addr), .wdata(pix_st_data),
    .rclk(mem_clk), .re(st_rd_fire), .raddr(st_rd_addr), .rdata(mem_st_data)
  );

endmodule

// File: rtl/rowbuf_ab_chk.sv
module rowbuf_ab_chk (
  input logic pix_clk,
  input logic pix_rst,
  input logic pix_sof,
  input logic pix_en,
  input logic pix_ready,
  input logic pix_ld_valid,
  input logic pix_underrun,
  input logic pix_overrun,
  input logic mem_clk,
  input logic mem_rst,
  input logic mem_st_re,
  input logic mem_st_rdy,
  input logic mem_st_valid
);

  a_r1_pix_reset_state: assert property (@(posedge pix_clk)
    pix_rst |=> (!pix_ready && !pix_ld_valid && !pix_underrun && !pix_overrun));

  a_r1_mem_reset_state: assert property (@(posedge mem_clk)
    mem_rst |=> (!mem_st_rdy && !mem_st_valid));

  a_r2_valid_after_step: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (pix_en && pix_ready) |=> pix_ld_valid);

  a_r2_no_valid_without_step: assert property (@(posedge pix_clk) disable iff (pix_rst)
    !(pix_en && pix_ready) |=> !pix_ld_valid);

  a_r3_valid_after_read: assert property (@(posedge mem_clk) disable iff (mem_rst)
    (mem_st_re && mem_st_rdy) |=> mem_st_valid);

  a_r7_underrun_sticky: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (pix_underrun && !pix_sof) |=> pix_underrun);

  a_r8_overrun_sticky: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (pix_overrun && !pix_sof) |=> pix_overrun);

  a_r9_sof_clears: assert property (@(posedge pix_clk) disable iff (pix_rst)
    pix_sof |=> (!pix_ready && !pix_underrun && !pix_overrun));

endmodule

bind rowbuf_ab rowbuf_ab_chk u_chk (
  .pix_clk(pix_clk), .pix_rst(pix_rst), .pix_sof(pix_sof), .pix_en(pix_en),
  .pix_ready(pix_ready), .pix_ld_valid(pix_ld_valid),
  .pix_underrun(pix_underrun), .pix_overrun(pix_overrun),
  .mem_clk(mem_clk), .mem_rst(mem_rst), .mem_st_re(mem_st_re),
  .mem_st_rdy(mem_st_rdy), .mem_st_valid(mem_st_valid)
);

// File: tb/rowbuf_ab_tb_top.sv
`timescale 1ns/1ps
module rowbuf_ab_tb_top;

  localparam int DW  = 128;
  localparam int ROW = 8;

  logic pclk = 1'b0;
  logic mclk = 1'b0;
  always #10 pclk = ~pclk;   // 50 MHz pixel clock
  always #3.5 mclk = ~mclk;  // faster memory clock

  logic          pix_rst = 1'b1, mem_rst = 1'b1;
  logic          pix_sof = 1'b0, pix_en = 1'b0;
  logic [DW-1:0] pix_st_data = '0;
  logic          pix_ready, pix_ld_valid, pix_underrun, pix_overrun;
  logic [DW-1:0] pix_ld_data;
  logic          mem_ld_we = 1'b0, mem_st_re = 1'b0;
  logic [DW-1:0] mem_ld_data = '0;
  logic          mem_ld_rdy, mem_st_rdy, mem_st_valid;
  logic [DW-1:0] mem_st_data;

  rowbuf_ab #(.DATA_W(DW), .ROW_WORDS(ROW)) dut_i (
    .pix_clk(pclk), .pix_rst(pix_rst), .pix_sof(pix_sof), .pix_en(pix_en),
    .pix_st_data(pix_st_data), .pix_ready(pix_ready), .pix_ld_valid(pix_ld_valid),
    .pix_ld_data(pix_ld_data), .pix_underrun(pix_underrun), .pix_overrun(pix_overrun),
    .mem_clk(mclk), .mem_rst(mem_rst), .mem_ld_we(mem_ld_we), .mem_ld_data(mem_ld_data),
    .mem_ld_rdy(mem_ld_rdy), .mem_st_re(mem_st_re), .mem_st_rdy(mem_st_rdy),
    .mem_st_valid(mem_st_valid), .mem_st_data(mem_st_data)
  );

  int n_chk = 0, n_fail = 0;
  int ld_idx = 0, ld_left = 0, px_rx = 0, px_left = 0, st_tx = 0, st_rx = 0;
  bit px_go = 1'b0, st_go = 1'b0, force_en = 1'b0;

  function automatic logic [DW-1:0] ldw(input int n);
    logic [31:0] u = n;
    return {u ^ 32'h5A5A_1234, u * 32'h9E37_79B1, ~u, u + 32'h0F0F_0F0F};
  endfunction

  function automatic logic [DW-1:0] stw(input int n);
    logic [31:0] u = n;
    return {u * 32'h85EB_CA6B, u ^ 32'hC3C3_0000, u + 32'h1357_9BDF, ~u ^ 32'h00FF_00FF};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory-side loader
  initial begin
    forever begin
      @(negedge mclk);
      if (ld_left > 0 && mem_ld_rdy && ($urandom % 3 != 0)) begin
        mem_ld_we   = 1'b1;
        mem_ld_data = ldw(ld_idx);
        ld_idx++;
        ld_left--;
      end else begin
        mem_ld_we = 1'b0;
      end
    end
  end

  // Memory-side drainer with R3 order check
  initial begin
    forever begin
      @(negedge mclk);
      if (mem_st_valid) begin
        chk(mem_st_data == stw(st_rx), "R3 store order", mem_st_data, stw(st_rx));
        st_rx++;
      end
      mem_st_re = st_go && mem_st_rdy && ($urandom % 3 != 0);
    end
  end

  // Pixel side with R2 order check
  initial begin
    forever begin
      @(negedge pclk);
      if (pix_ld_valid) begin
        chk(pix_ld_data == ldw(px_rx), "R2 load order", pix_ld_data, ldw(px_rx));
        px_rx++;
      end
      if (force_en) begin
        pix_en   = 1'b1;
        force_en = 1'b0;
      end else if (px_go && px_left > 0 && pix_ready && ($urandom % 4 != 0)) begin
        pix_en      = 1'b1;
        pix_st_data = stw(st_tx);
        st_tx++;
        px_left--;
      end else begin
        pix_en = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge pclk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic force_step();
    @(posedge pclk); #2 force_en = 1'b1;
    @(negedge pclk);
    @(negedge pclk);
  endtask

  initial begin
    void'($urandom(32'd20260227));
    repeat (5) @(posedge pclk);
    #2 pix_rst = 1'b0;
    @(posedge mclk); #1 mem_rst = 1'b0;
    repeat (4) @(negedge pclk);

    // R1 reset state
    chk(pix_ready == 1'b0, "R1 pix_ready", pix_ready, 0);
    chk(pix_ld_valid == 1'b0, "R1 pix_ld_valid", pix_ld_valid, 0);
    chk(pix_underrun == 1'b0, "R1 pix_underrun", pix_underrun, 0);
    chk(pix_overrun == 1'b0, "R1 pix_overrun", pix_overrun, 0);
    @(negedge mclk);
    chk(mem_ld_rdy == 1'b1, "R1 mem_ld_rdy", mem_ld_rdy, 1);
    chk(mem_st_rdy == 1'b0, "R1 mem_st_rdy", mem_st_rdy, 0);
    chk(mem_st_valid == 1'b0, "R1 mem_st_valid", mem_st_valid, 0);

    // R4 partial row is not enough
    ld_left = ROW - 1;
    wait (ld_left == 0);
    repeat (20) @(negedge pclk);
    chk(pix_ready == 1'b0, "R4 partial row", pix_ready, 0);
    ld_left = 1;
    wait (ld_left == 0);
    repeat (10) @(negedge pclk);
    chk(pix_ready == 1'b1, "R4 full row", pix_ready, 1);
    @(negedge mclk);
    chk(mem_ld_rdy == 1'b1, "R5 bank B still free", mem_ld_rdy, 1);

    // Consume row 0; bank B of load channel stays empty
    px_go   = 1'b1;
    px_left = ROW;
    wait (px_left == 0);
    repeat (10) @(negedge pclk);
    chk(pix_ready == 1'b0, "R7 next load bank empty", pix_ready, 0);
    @(negedge mclk);
    chk(mem_st_rdy == 1'b1, "R6 stored row waiting", mem_st_rdy, 1);

    // R7 underrun
    force_step();
    chk(pix_underrun == 1'b1, "R7 underrun set", pix_underrun, 1);
    chk(pix_overrun == 1'b0, "R7 no overrun", pix_overrun, 0);
    chk(pix_ld_valid == 1'b0, "R7 request dropped", pix_ld_valid, 0);

    // R5 two rows ahead
    ld_left = 2 * ROW;
    wait (ld_left == 0);
    repeat (10) @(negedge mclk);
    chk(mem_ld_rdy == 1'b0, "R5 both load banks full", mem_ld_rdy, 0);
    px_left = ROW;
    wait (px_left == 0);
    repeat (10) @(negedge pclk);
    @(negedge mclk);
    chk(mem_ld_rdy == 1'b1, "R5 bank released", mem_ld_rdy, 1);

    // R8 overrun: both store banks undrained
    @(negedge pclk);
    chk(pix_ready == 1'b0, "R6 store banks pending", pix_ready, 0);
    force_step();
    chk(pix_overrun == 1'b1, "R8 overrun set", pix_overrun, 1);
    chk(pix_underrun == 1'b1, "R7 underrun sticky", pix_underrun, 1);

    // Drain both stored rows
    st_go = 1'b1;
    wait (st_rx == 2 * ROW);
    repeat (10) @(negedge pclk);
    st_go = 1'b0;
    chk(pix_ready == 1'b1, "R6 ready after drain", pix_ready, 1);
    @(negedge mclk);
    chk(mem_st_rdy == 1'b0, "R6 nothing left to drain", mem_st_rdy, 0);

    // R9 start-of-frame while a loaded row is pending
    @(posedge pclk); #2 pix_sof = 1'b1;
    @(posedge pclk); #2 pix_sof = 1'b0; force_en = 1'b1;
    @(negedge pclk);
    @(negedge pclk);
    chk(pix_underrun == 1'b0, "R9 underrun cleared", pix_underrun, 0);
    chk(pix_overrun == 1'b0, "R9 overrun cleared", pix_overrun, 0);
    chk(pix_ready == 1'b0, "R9 ready low in flush", pix_ready, 0);
    repeat (40) @(negedge pclk);
    chk(pix_ready == 1'b0, "R9 pending row discarded", pix_ready, 0);
    chk(pix_underrun == 1'b0, "R9 flush step sets no flag", pix_underrun, 0);
    @(negedge mclk);
    chk(mem_st_rdy == 1'b0, "R9 store banks empty", mem_st_rdy, 0);
    chk(mem_ld_rdy == 1'b1, "R9 load bank A free", mem_ld_rdy, 1);

    // Random streaming after the flush
    ld_idx  = 1000;
    px_rx   = 1000;
    st_tx   = 5000;
    st_rx   = 5000;
    st_go   = 1'b1;
    ld_left = 6 * ROW;
    px_left = 6 * ROW;
    wait (px_left == 0);
    wait (st_rx == st_tx);
    repeat (10) @(negedge pclk);
    chk(px_rx == 1000 + 6 * ROW, "R2 word count", px_rx, 1000 + 6 * ROW);
    chk(st_rx == 5000 + 6 * ROW, "R3 word count", st_rx, 5000 + 6 * ROW);
    chk(pix_underrun == 1'b0 && pix_overrun == 1'b0, "R7 R8 no flags when paced",
        {pix_underrun, pix_overrun}, 0);

    finish_run();
  end

endmodule